// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block is a full-duplex serial port that moves 8-bit words over a shared transfer clock. There are no start, stop or parity bits. The processor side writes a word into a transmit holding register and reads received words from a receive holding register. Control inputs select the following:

- where the transfer clock comes from,
- which clock edge launches and which edge captures data,
- the bit order,
- when the transmit interrupt fires,
- whether reading the receive word starts the next reception automatically.

The transfer clock has two sources. The first is an on-chip divider that counts ticks from one of three prescaled enables. The second is an external clock pin, which is synchronised and edge-detected inside the block. Reception is tied to transmission: a word is shifted in only while a word is being shifted out. A receive word that is still unread when the next word reaches its seventh bit is reported as an overrun.

Top module: `sync_serial_port`

## Requirements
- R1: Every transfer has exactly 8 launch edges and 8 capture edges. The transfer ends on the 8th capture edge, and no further edges follow.
- R2: In divider mode, each half period of `sclk_out` is (`divisor`+1) ticks of the source enable picked by `src_sel`. Codes 0, 1 and 2 pick `src_tick[0]`, `src_tick[1]` and `src_tick[2]`.
- R3: In external-clock mode (`ext_clk_sel`=1), edges come from `ext_clk_in` and `sclk_out` stays at its idle level. A transfer starts only while the synchronised pin is at the idle level.
- R4: A transfer starts only when `tx_en`=1 and the transmit holding register is full. While `tx_en`=0, a written word stays pending and no clock edges are produced.
- R5: A word is received only if `rx_en`=1 when the transfer starts. Otherwise `rx_irq` stays low and `rd_data` keeps its earlier value.
- R6: With `tx_irq_on_done`=0, `tx_irq` pulses in the cycle the word leaves the holding register, which is also the cycle `tx_empty` returns to 1. With `tx_irq_on_done`=1, it pulses at the 8th capture edge.
- R7: `rx_irq` pulses once per received word, at the 8th capture edge. In that same cycle `rd_data` shows the new word.
- R8: If the previous word has not been read when the 7th capture edge of a new word occurs, `overrun` goes to 1 at that edge. The new word then raises no `rx_irq`, and a read clears `overrun`.
- R9: The idle clock level is the inverse of `polarity`. Data is launched on the edge that leaves the idle level and captured on the edge that returns to it.
- R10: With `msb_first`=1, bit 7 travels first in both directions. With `msb_first`=0, bit 0 travels first.
- R11: With `cont_rx`=1, a read pulse on `rd_rx` starts a new transfer without a new write. That transfer sends the previous transmit word again. With `cont_rx`=0, a read starts nothing.
- R12: `tx_empty` is 1 after reset, drops to 0 on a write, and returns to 1 when a transfer takes the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| ext_clk_sel | input | 1 | 1 selects the external clock pin |
| polarity | input | 1 | Clock polarity; idle level is its inverse |
| msb_first | input | 1 | Bit order select |
| tx_irq_on_done | input | 1 | Transmit interrupt at end (1) or at load (0) |
| cont_rx | input | 1 | Continuous-receive mode |
| src_sel | input | 2 | Source enable select for the divider |
| divisor | input | 8 | Divider setting n |
| src_tick | input | 3 | Prescaled source clock enables |
| wr_tx | input | 1 | Write strobe for the transmit holding register |
| wr_data | input | 8 | Word to transmit |
| rd_rx | input | 1 | Read strobe for the receive holding register |
| rd_data | output | 8 | Receive holding register |
| tx_empty | output | 1 | Transmit holding register empty |
| ext_clk_in | input | 1 | External transfer clock pin |
| sclk_out | output | 1 | Transfer clock output in divider mode |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| tx_irq | output | 1 | Transmit interrupt pulse |
| rx_irq | output | 1 | Receive interrupt pulse |
| overrun | output | 1 | Overrun flag |

## Verification
The bench sweeps every combination of polarity, bit order and source select, using three divisor values. It times each half period, so a divider that counts n ticks instead of n+1 shows up as a period error. Swapped launch and capture edges corrupt the received word, because the bench changes `sdi` only on launch edges. The overrun case checks the flag after the 6th and after the 7th capture edge. A design that flags one bit early or late, or that still raises `rx_irq` for the damaged word, fails there. The gating cases stall the transfer on a disabled transmitter, on an external clock parked away from idle, and on a read with continuous mode off. A block that starts anyway produces edges that the bench counts.

// File: rtl/ssp_pkg.sv
package ssp_pkg;

  // Clamp a source select code onto the available enables.
  function automatic int unsigned sel_clamp(input int unsigned code, input int unsigned n_src);
    return (code >= n_src) ? n_src - 1 : code;
  endfunction

  // Half period in source ticks for a divisor setting.
  function automatic int unsigned half_ticks(input int unsigned n);
    return n + 1;
  endfunction

  // Position of the capture edge that triggers the overrun test (0-based).
  function automatic int unsigned ovr_index(input int unsigned width);
    return width - 2;
  endfunction

endpackage

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int DIV_W   = 8,
  parameter int NUM_SRC = 3,
  parameter int SEL_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               busy,
  input  logic               ext_sel,
  input  logic               polarity,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [DIV_W-1:0]   divisor,
  input  logic               ext_clk_in,
  output logic               ext_lvl,
  output logic               lead_evt,
  output logic               trail_evt,
  output logic               sclk_q
);
  import ssp_pkg::*;

  logic [2:0]       ext_sync;
  logic [DIV_W-1:0] cnt;
  logic             tick, half_hit, int_edge, ext_edge, idle_lvl;

  assign idle_lvl = ~polarity;
  assign ext_lvl  = ext_sync[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_sync <= '0;
    else        ext_sync <= {ext_sync[1:0], ext_clk_in};
  end

  always_comb begin
    tick = src_tick[sel_clamp(int'(src_sel), NUM_SRC)];
  end

  assign half_hit = tick && (cnt == divisor);
  assign int_edge = busy && !ext_sel && half_hit;
  assign ext_edge = busy && ext_sel && (ext_sync[1] ^ ext_sync[2]);

  always_comb begin
    lead_evt  = 1'b0;
    trail_evt = 1'b0;
    if (int_edge) begin
      lead_evt  = (sclk_q == idle_lvl);
      trail_evt = (sclk_q != idle_lvl);
    end else if (ext_edge) begin
      lead_evt  = (ext_lvl != idle_lvl);
      trail_evt = (ext_lvl == idle_lvl);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b1;
    end else if (!busy || ext_sel) begin
      cnt    <= '0;
      sclk_q <= idle_lvl;
    end else if (tick) begin
      if (cnt == divisor) begin
        cnt    <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/ssp_shifter.sv
module ssp_shifter #(
  parameter int DATA_W = 8,
  localparam int CNT_W = $clog2(DATA_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              msb_first,
  input  logic              lead_evt,
  input  logic              trail_evt,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rx_next,
  output logic              done_evt,
  output logic              ovr_point
);
  import ssp_pkg::*;

  localparam int LAST_IDX = DATA_W - 1;
  localparam int OVR_IDX  = ovr_index(DATA_W);

  logic [DATA_W-1:0] tx_sh, rx_sh;
  logic [CNT_W-1:0]  tcnt;

  always_comb begin
    if (msb_first) rx_next = {rx_sh[DATA_W-2:0], sdi};
    else           rx_next = {sdi, rx_sh[DATA_W-1:1]};
  end

  assign done_evt  = trail_evt && (tcnt == CNT_W'(LAST_IDX));
  assign ovr_point = trail_evt && (tcnt == CNT_W'(OVR_IDX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh <= '0;
      rx_sh <= '0;
      tcnt  <= '0;
      sdo   <= 1'b1;
    end else begin
      if (load) begin
        tx_sh <= load_data;
        tcnt  <= '0;
      end else begin
        if (lead_evt) begin
          if (msb_first) begin
            sdo   <= tx_sh[DATA_W-1];
            tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
          end else begin
            sdo   <= tx_sh[0];
            tx_sh <= {1'b0, tx_sh[DATA_W-1:1]};
          end
        end
        if (trail_evt) begin
          rx_sh <= rx_next;
          tcnt  <= tcnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ssp_rx_stage.sv
module ssp_rx_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_evt,
  input  logic              rx_en,
  input  logic              cont_rx,
  input  logic              done_evt,
  input  logic              ovr_point,
  input  logic              rd_rx,
  input  logic [DATA_W-1:0] rx_next,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_irq,
  output logic              overrun,
  output logic              rearm,
  output logic              rx_armed
);
  logic rx_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_buf   <= '0;
      rx_irq   <= 1'b0;
      overrun  <= 1'b0;
      rearm    <= 1'b0;
      rx_armed <= 1'b0;
      rx_full  <= 1'b0;
    end else begin
      rx_irq <= 1'b0;
      if (start_evt) begin
        rx_armed <= rx_en;
        rearm    <= 1'b0;
      end
      if (ovr_point && rx_armed && rx_full) overrun <= 1'b1;
      if (rd_rx) begin
        rx_full <= 1'b0;
        overrun <= 1'b0;
        if (cont_rx) rearm <= 1'b1;
      end
      if (done_evt && rx_armed) begin
        rx_buf   <= rx_next;
        rx_armed <= 1'b0;
        if (!overrun) begin
          rx_full <= 1'b1;
          rx_irq  <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/sync_serial_port.sv
module sync_serial_port #(
  parameter int DATA_W  = 8,
  parameter int DIV_W   = 8,
  parameter int NUM_SRC = 3,
  localparam int SEL_W  = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_en,
  input  logic               rx_en,
  input  logic               ext_clk_sel,
  input  logic               polarity,
  input  logic               msb_first,
  input  logic               tx_irq_on_done,
  input  logic               cont_rx,
  input  logic [SEL_W-1:0]   src_sel,
  input  logic [DIV_W-1:0]   divisor,
  input  logic [NUM_SRC-1:0] src_tick,
  input  logic               wr_tx,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_rx,
  output logic [DATA_W-1:0]  rd_data,
  output logic               tx_empty,
  input  logic               ext_clk_in,
  output logic               sclk_out,
  output logic               sdo,
  input  logic               sdi,
  output logic               tx_irq,
  output logic               rx_irq,
  output logic               overrun
);

  logic [DATA_W-1:0] tx_buf, rx_next;
  logic              tx_empty_q, busy, tx_irq_q;
  logic              ext_lvl, lead_evt, trail_evt, done_evt, ovr_point;
  logic              start_evt, rearm, rx_armed, idle_lvl;

  assign idle_lvl = ~polarity;

  always_comb begin
    start_evt = !busy && tx_en
             && (!tx_empty_q || (cont_rx && rearm && rx_en))
             && (!ext_clk_sel || (ext_lvl == idle_lvl));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf     <= '0;
      tx_empty_q <= 1'b1;
      busy       <= 1'b0;
      tx_irq_q   <= 1'b0;
    end else begin
      tx_irq_q <= 1'b0;
      if (start_evt) begin
        busy       <= 1'b1;
        tx_empty_q <= 1'b1;
        if (!tx_irq_on_done) tx_irq_q <= 1'b1;
      end
      if (done_evt) begin
        busy <= 1'b0;
        if (tx_irq_on_done) tx_irq_q <= 1'b1;
      end
      if (wr_tx) begin
        tx_buf     <= wr_data;
        tx_empty_q <= 1'b0;
      end
    end
  end

  ssp_clkgen #(.DIV_W(DIV_W), .NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .busy(busy), .ext_sel(ext_clk_sel),
    .polarity(polarity), .src_tick(src_tick), .src_sel(src_sel),
    .divisor(divisor), .ext_clk_in(ext_clk_in), .ext_lvl(ext_lvl),
    .lead_evt(lead_evt), .trail_evt(trail_evt), .sclk_q(sclk_out)
  );

  ssp_shifter #(.DATA_W(DATA_W)) shifter_i (
    .clk(clk), .rst_n(rst_n), .load(start_evt), .load_data(tx_buf),
    .msb_first(msb_first), .lead_evt(lead_evt), .trail_evt(trail_evt),
    .sdi(sdi), .sdo(sdo), .rx_next(rx_next), .done_evt(done_evt),
    .ovr_point(ovr_point)
  );

  ssp_rx_stage #(.DATA_W(DATA_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .start_evt(start_evt), .rx_en(rx_en),
    .cont_rx(cont_rx), .done_evt(done_evt), .ovr_point(ovr_point),
    .rd_rx(rd_rx), .rx_next(rx_next), .rx_buf(rd_data), .rx_irq(rx_irq),
    .overrun(overrun), .rearm(rearm), .rx_armed(rx_armed)
  );

  assign tx_empty = tx_empty_q;
  assign tx_irq   = tx_irq_q;

endmodule

// File: rtl/sync_serial_port_chk.sv
module sync_serial_port_chk #(
  parameter int DATA_W = 8
) (
  input logic clk,
  input logic rst_n,
  input logic tx_en,
  input logic ext_clk_sel,
  input logic polarity,
  input logic tx_irq_on_done,
  input logic start_evt,
  input logic done_evt,
  input logic trail_evt,
  input logic busy,
  input logic ext_lvl,
  input logic rx_armed,
  input logic sclk_out,
  input logic tx_irq,
  input logic rx_irq,
  input logic overrun
);
  localparam int CW = $clog2(DATA_W + 1);

  logic [CW-1:0] trail_seen;
  logic          warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trail_seen <= '0;
      warm       <= 1'b0;
    end else begin
      warm <= 1'b1;
      if (start_evt)      trail_seen <= '0;
      else if (trail_evt) trail_seen <= trail_seen + 1'b1;
    end
  end

  p_eight_bits_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> (trail_seen == CW'(DATA_W - 1)));

  p_ext_idle_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && ext_clk_sel) |-> (ext_lvl == !polarity));

  p_start_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> (tx_en && !busy));

  p_rx_needs_arm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $past(rx_armed));

  p_txirq_early_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt && !tx_irq_on_done) |=> tx_irq);

  p_txirq_late_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt && tx_irq_on_done) |=> tx_irq);

  p_ovr_no_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> !overrun);

  p_idle_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !busy && !ext_clk_sel && $stable(polarity)) |-> (sclk_out == !polarity));

endmodule

bind sync_serial_port sync_serial_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .ext_clk_sel(ext_clk_sel),
  .polarity(polarity), .tx_irq_on_done(tx_irq_on_done),
  .start_evt(start_evt), .done_evt(done_evt), .trail_evt(trail_evt),
  .busy(busy), .ext_lvl(ext_lvl), .rx_armed(rx_armed), .sclk_out(sclk_out),
  .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun)
);

// File: tb/sync_serial_port_tb_top.sv
`timescale 1ns/1ps
module sync_serial_port_tb_top;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, tx_en, rx_en, ext_clk_sel, polarity, msb_first, tx_irq_on_done, cont_rx;
  logic [1:0] src_sel;
  logic [7:0] divisor, wr_data, rd_data;
  logic [2:0] src_tick;
  logic wr_tx, rd_rx, tx_empty, ext_clk_in, sclk_out, sdo, sdi, tx_irq, rx_irq, overrun;

  sync_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .rx_en(rx_en),
    .ext_clk_sel(ext_clk_sel), .polarity(polarity), .msb_first(msb_first),
    .tx_irq_on_done(tx_irq_on_done), .cont_rx(cont_rx), .src_sel(src_sel),
    .divisor(divisor), .src_tick(src_tick), .wr_tx(wr_tx), .wr_data(wr_data),
    .rd_rx(rd_rx), .rd_data(rd_data), .tx_empty(tx_empty),
    .ext_clk_in(ext_clk_in), .sclk_out(sclk_out), .sdo(sdo), .sdi(sdi),
    .tx_irq(tx_irq), .rx_irq(rx_irq), .overrun(overrun)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  // monitor state
  bit   mon_on = 0, ovr_watch = 0, exp_msb = 0, exp_txsel = 0;
  logic exp_idle = 1'b1;
  logic prev_sclk = 1'b1;
  int   lead_n = 0, trail_n = 0, edge_n = 0, last_edge = 0, exp_half = 1;
  int   txirq_n = 0, rxirq_n = 0;
  logic [7:0] cap, exp_rx;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic wbit(input logic [7:0] d, input int i, input bit msb);
    return msb ? d[7-i] : d[i];
  endfunction

  function automatic logic [7:0] assemble(input logic [7:0] w, input bit msb);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[msb ? 7-i : i] = w[i];
    return r;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  initial begin
    src_tick = 3'b111;
    forever begin
      @(negedge clk);
      src_tick = {(cyc % 4) == 0, (cyc % 2) == 0, 1'b1};
    end
  end

  // Responder and monitor for divider mode
  always @(negedge clk) begin
    if (mon_on && (sclk_out !== prev_sclk)) begin
      if (edge_n > 0) chk((cyc - last_edge) == exp_half, "R2 half period", cyc - last_edge, exp_half);
      last_edge = cyc;
      edge_n++;
      if (sclk_out !== exp_idle) begin
        if (lead_n < 8) cap[lead_n] = sdo;
        if (lead_n < 8) sdi = wbit(exp_rx, lead_n, exp_msb);
        lead_n++;
      end else begin
        trail_n++;
        if (ovr_watch && trail_n == 6) chk(overrun == 1'b0, "R8 before 7th bit", overrun, 0);
        if (ovr_watch && trail_n == 7) chk(overrun == 1'b1, "R8 at 7th bit", overrun, 1);
      end
    end
    prev_sclk = sclk_out;
    if (tx_irq) begin
      txirq_n++;
      if (mon_on) begin
        if (exp_txsel) chk(trail_n == 8, "R6 irq at end", trail_n, 8);
        else chk(lead_n == 0 && tx_empty == 1'b1, "R6 irq at load", lead_n, 0);
      end
    end
    if (rx_irq) begin
      rxirq_n++;
      if (mon_on) begin
        chk(trail_n == 8, "R7 irq timing", trail_n, 8);
        chk(rd_data == exp_rx, "R7 rx word", rd_data, exp_rx);
      end
    end
  end

  task automatic setup_int(input bit pol, input bit msb, input int sel, input int dv,
                           input bit tsel, input logic [7:0] rxd);
    mon_on = 0;
    ext_clk_sel = 0; polarity = pol; msb_first = msb; src_sel = 2'(sel);
    divisor = 8'(dv); tx_irq_on_done = tsel;
    exp_idle = ~pol; exp_msb = msb; exp_txsel = tsel; exp_rx = rxd;
    exp_half = (dv + 1) * (1 << sel);
    repeat (3) @(negedge clk);
    lead_n = 0; trail_n = 0; edge_n = 0;
    mon_on = 1;
  endtask

  task automatic write_word(input logic [7:0] d);
    wr_data = d; wr_tx = 1;
    @(negedge clk);
    wr_tx = 0;
    chk(tx_empty == 1'b0, "R12 write clears empty", tx_empty, 0);
  endtask

  task automatic read_word();
    rd_rx = 1;
    @(negedge clk);
    rd_rx = 0;
  endtask

  task automatic finish_xfer(input logic [7:0] txd);
    wait (trail_n == 8);
    repeat (2 * exp_half + 4) @(negedge clk);
    chk(lead_n == 8 && trail_n == 8, "R1 edge count", lead_n * 16 + trail_n, 8 * 16 + 8);
    chk(assemble(cap, exp_msb) == txd, "R10 tx order", assemble(cap, exp_msb), txd);
    chk(sclk_out == exp_idle, "R9 idle level", sclk_out, exp_idle);
  endtask

  task automatic xfer_ext(input bit pol, input bit msb, input logic [7:0] txd, input logic [7:0] rxd);
    logic idle;
    int   rx0;
    mon_on = 0;
    idle = ~pol;
    ext_clk_sel = 1; polarity = pol; msb_first = msb; tx_irq_on_done = 0;
    ext_clk_in = ~idle;
    repeat (4) @(negedge clk);
    write_word(txd);
    repeat (8) @(negedge clk);
    chk(tx_empty == 1'b0, "R3 no start off idle", tx_empty, 0);
    ext_clk_in = idle;
    repeat (5) @(negedge clk);
    chk(tx_empty == 1'b1, "R3 start at idle", tx_empty, 1);
    rx0 = rxirq_n;
    for (int i = 0; i < 8; i++) begin
      ext_clk_in = ~idle;
      repeat (5) @(negedge clk);
      cap[i] = sdo;
      sdi = wbit(rxd, i, msb);
      ext_clk_in = idle;
      repeat (5) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    chk(sclk_out == idle, "R3 sclk held idle", sclk_out, idle);
    chk(rxirq_n == rx0 + 1, "R3 rx irq", rxirq_n, rx0 + 1);
    chk(rd_data == rxd, "R3 rx word", rd_data, rxd);
    chk(assemble(cap, msb) == txd, "R3 tx word", assemble(cap, msb), txd);
    read_word();
  endtask

  initial begin
    wait (cyc >= 150000);
    miscompares++;
    $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    int rx0, tx0, idx;
    logic [7:0] txd, rxd, keep;
    rst_n = 0; tx_en = 1; rx_en = 1; ext_clk_sel = 0; polarity = 0; msb_first = 0;
    tx_irq_on_done = 0; cont_rx = 0; src_sel = 0; divisor = 0; wr_tx = 0; wr_data = 0;
    rd_rx = 0; ext_clk_in = 1; sdi = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(tx_empty == 1'b1, "R12 reset empty", tx_empty, 1);
    chk(tx_irq == 1'b0, "R6 reset", tx_irq, 0);
    chk(rx_irq == 1'b0, "R7 reset", rx_irq, 0);
    chk(overrun == 1'b0, "R8 reset", overrun, 0);
    chk(sclk_out == 1'b1, "R9 reset idle", sclk_out, 1);

    // Sweep polarity, order, source and divisor
    idx = 0;
    for (int pol = 0; pol < 2; pol++)
      for (int msb = 0; msb < 2; msb++)
        for (int sel = 0; sel < 3; sel++)
          for (int k = 0; k < 3; k++) begin
            txd = 8'h3C ^ 8'(idx * 29);
            rxd = 8'hC5 + 8'(idx * 53);
            setup_int(pol[0], msb[0], sel, (k == 2) ? 3 : k, idx[0], rxd);
            rx0 = rxirq_n; tx0 = txirq_n;
            write_word(txd);
            finish_xfer(txd);
            chk(rxirq_n == rx0 + 1, "R7 one rx irq", rxirq_n, rx0 + 1);
            chk(txirq_n == tx0 + 1, "R6 one tx irq", txirq_n, tx0 + 1);
            read_word();
            idx++;
          end

    // R4: transmitter disabled holds the word
    setup_int(0, 0, 0, 1, 0, 8'h96);
    tx_en = 0;
    write_word(8'h1E);
    repeat (40) @(negedge clk);
    chk(tx_empty == 1'b0, "R4 word pending", tx_empty, 0);
    chk(lead_n == 0, "R4 no edges", lead_n, 0);
    tx_en = 1;
    finish_xfer(8'h1E);
    read_word();

    // R5: receiver disabled
    keep = rd_data;
    rx_en = 0;
    setup_int(1, 1, 0, 0, 0, 8'h5A);
    rx0 = rxirq_n;
    write_word(8'hE1);
    finish_xfer(8'hE1);
    chk(rxirq_n == rx0, "R5 no rx irq", rxirq_n, rx0);
    chk(rd_data == keep, "R5 rx word kept", rd_data, keep);
    rx_en = 1;

    // R8: overrun on unread word
    setup_int(0, 1, 0, 1, 0, 8'h71);
    write_word(8'h0F);
    finish_xfer(8'h0F);
    rx0 = rxirq_n;
    setup_int(0, 1, 0, 1, 0, 8'h8E);
    ovr_watch = 1;
    write_word(8'hF0);
    finish_xfer(8'hF0);
    ovr_watch = 0;
    chk(rxirq_n == rx0, "R8 no irq on overrun", rxirq_n, rx0);
    chk(overrun == 1'b1, "R8 flag held", overrun, 1);
    read_word();
    chk(overrun == 1'b0, "R8 read clears", overrun, 0);

    // R11: read without continuous mode starts nothing
    setup_int(0, 0, 0, 0, 0, 8'h00);
    read_word();
    repeat (40) @(negedge clk);
    chk(lead_n == 0, "R11 no restart", lead_n, 0);

    // R11: continuous mode restarts on read
    cont_rx = 1;
    setup_int(1, 0, 1, 0, 1, 8'hA3);
    rx0 = rxirq_n;
    write_word(8'h4D);
    finish_xfer(8'h4D);
    chk(rxirq_n == rx0 + 1, "R11 first word", rxirq_n, rx0 + 1);
    setup_int(1, 0, 1, 0, 1, 8'h3B);
    read_word();
    finish_xfer(8'h4D);
    chk(rxirq_n == rx0 + 2, "R11 rearmed word", rxirq_n, rx0 + 2);
    chk(rd_data == 8'h3B, "R11 rx word", rd_data, 8'h3B);
    chk(tx_empty == 1'b1, "R11 no new write", tx_empty, 1);
    cont_rx = 0;
    read_word();

    // R3: external clock, both polarities and orders
    xfer_ext(0, 0, 8'hB4, 8'h2D);
    xfer_ext(1, 1, 8'h69, 8'hD2);
    xfer_ext(1, 0, 8'h07, 8'hE0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule